// File: doc/BRIEF.md
# Glitch-Free Clock Output Shutdown Controller

This block sits between a set of divided clocks and their output pads and decides, for each output, whether the clock passes or is parked low. Each output group has an active-low stop pin. A common active-low stop pin halts every main output but not the feedback output. All control pins are first brought into the internal clock domain through a synchronizer chain. Each gate may only change state while its divided clock is low, so a stopped output never ends on a shortened high phase and a restarted output always begins with a whole one.

An active-high master drive enable sits above the stop pins. When it is low, the per-output drive-enable flags all drop, so the pad stage can float every output, the feedback output included. The clock gating keeps running underneath, unaffected. The divided clocks are data signals in the internal clock domain. Every output, gated or not, is registered once, so all outputs share one cycle of latency.

Top module: `clk_shutdown_ctrl`

## Requirements
- R1: While reset is asserted, every gated clock output and the feedback output are low, and every drive-enable flag is low.
- R2: An output whose stop pins are both high repeats its divided clock one internal clock cycle later, with no change to the waveform.
- R3: Stop pin bit 0 controls outputs 0 and 1 together. Stop pin bit k, for k from 1 to 4, controls only output k+1. Stopping one group leaves the other outputs running.
- R4: A stopped output is held low. Every high pulse on a gated output lasts exactly one full high phase of its divided clock. This holds even when the stop request arrives in the middle of a high phase.
- R5: A stop pin passes through a two-stage synchronizer. A high phase of the divided clock that begins one cycle after the pin falls is still delivered whole.
- R6: When a stop pin returns high, the output resumes at a later rising edge of its divided clock, and its first pulse is full width.
- R7: Driving the common stop pin low halts all six gated outputs. The feedback output keeps following its divided clock.
- R8: Driving the master enable low clears every drive-enable flag, the feedback flag included, within three internal clock cycles, whatever the state of the stop pins.
- R9: The master enable does not change the gated clock waveforms, and the stop pins do not change the drive-enable flags.
- R10: The feedback output always repeats its divided clock one cycle later, whatever the stop pins are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all state is registered on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_clk | input | 6 | Divided clocks, one per main output, synchronous to clk |
| fb_div_clk | input | 1 | Divided clock for the feedback output |
| grp_sd_n | input | 5 | Active-low stop pins; bit 0 covers outputs 0 and 1, bit k covers output k+1 |
| all_sd_n | input | 1 | Active-low common stop pin for all main outputs |
| out_en | input | 1 | Active-high master drive enable |
| q_clk | output | 6 | Gated clock outputs |
| q_drv | output | 6 | Per-output drive-enable flags (low means high impedance) |
| fb_clk | output | 1 | Feedback clock output, never gated |
| fb_drv | output | 1 | Drive-enable flag of the feedback output |

## Verification
The hardest case to reach from the ports is a stop request that falls exactly one cycle before its divided clock rises. Only the synchronizer delay decides whether that pulse is delivered whole or suppressed. The bench generates the divided clocks itself and knows each divider's phase. It waits until the divider of output 5 sits two cycles from its rising edge, drops the stop pin at that point, and then expects one full pulse followed by silence. A second scenario lowers a stop pin on the cycle right after output 4 rises. A pulse-width monitor then has to show that the pulse already in flight runs to its natural end.

// File: rtl/csd_pkg.sv
package csd_pkg;

   // Maps a main output index to the stop pin that governs it.
   // With pairing on, outputs 0 and 1 share pin 0 and output n (n>1) uses pin n-1.
   function automatic int sd_index(input int out_idx, input int pair_low);
      if (pair_low != 0) begin
         if (out_idx == 0) return 0;
         return out_idx - 1;
      end
      return out_idx;
   endfunction

   // Number of stop pins for a given output count and pairing option.
   function automatic int sd_count(input int num_out, input int pair_low);
      return num_out - ((pair_low != 0) ? 1 : 0);
   endfunction

endpackage

// File: rtl/csd_sync.sv
module csd_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("csd_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("csd_sync: WIDTH must be at least 1");
      end

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/csd_gate.sv
module csd_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic div,
   input  logic run_req,
   output logic q
);

   logic pass_r;
   logic pass_nxt;

   // The pass decision is frozen for the whole high phase of the divided clock.
   // It may only take the requested value while that clock is low.
   always_comb begin
      pass_nxt = pass_r;
      if (!div) pass_nxt = run_req;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pass_r <= 1'b0;
         q      <= 1'b0;
      end else begin
         pass_r <= pass_nxt;
         q      <= div & pass_nxt;
      end
   end

endmodule

// File: rtl/clk_shutdown_ctrl.sv
module clk_shutdown_ctrl #(
   parameter int NUM_OUT     = 6,
   parameter int PAIR_LOW    = 1,
   parameter int SYNC_STAGES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_OUT-1:0]            div_clk,
   input  logic                          fb_div_clk,
   input  logic [NUM_OUT-PAIR_LOW-1:0]   grp_sd_n,
   input  logic                          all_sd_n,
   input  logic                          out_en,
   output logic [NUM_OUT-1:0]            q_clk,
   output logic [NUM_OUT-1:0]            q_drv,
   output logic                          fb_clk,
   output logic                          fb_drv
);

   localparam int NUM_SD  = csd_pkg::sd_count(NUM_OUT, PAIR_LOW);
   localparam int CTL_W   = NUM_SD + 2;
   localparam int IDX_ALL = NUM_SD;
   localparam int IDX_OE  = NUM_SD + 1;

   generate
      if (NUM_OUT < 2) begin : g_bad_out
         $error("clk_shutdown_ctrl: NUM_OUT must be at least 2");
      end
      if (PAIR_LOW != 0 && PAIR_LOW != 1) begin : g_bad_pair
         $error("clk_shutdown_ctrl: PAIR_LOW must be 0 or 1");
      end
      if (SYNC_STAGES < 2 || SYNC_STAGES > 8) begin : g_bad_sync
         $error("clk_shutdown_ctrl: SYNC_STAGES must lie in 2..8");
      end
   endgenerate

   logic [CTL_W-1:0]  ctl_raw;
   logic [CTL_W-1:0]  ctl_syn;
   logic [NUM_SD-1:0] grp_run;
   logic              all_run;
   logic              oe_syn;
   logic              fb_q;

   assign ctl_raw = {out_en, all_sd_n, grp_sd_n};

   csd_sync #(
      .WIDTH  (CTL_W),
      .STAGES (SYNC_STAGES)
   ) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_syn)
   );

   assign grp_run = ctl_syn[NUM_SD-1:0];
   assign all_run = ctl_syn[IDX_ALL];
   assign oe_syn  = ctl_syn[IDX_OE];

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
         localparam int SDI = csd_pkg::sd_index(i, PAIR_LOW);
         logic run_req;

         if (PAIR_LOW != 0 && i < 2) begin : g_shared
            assign run_req = grp_run[0] & all_run;
         end else begin : g_own
            assign run_req = grp_run[SDI] & all_run;
         end

         csd_gate u_gate (
            .clk     (clk),
            .rst_n   (rst_n),
            .div     (div_clk[i]),
            .run_req (run_req),
            .q       (q_clk[i])
         );

         assign q_drv[i] = oe_syn;
      end
   endgenerate

   // The feedback path is never gated; one register keeps it aligned with the gated outputs.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fb_q <= 1'b0;
      else        fb_q <= fb_div_clk;
   end

   assign fb_clk = fb_q;
   assign fb_drv = oe_syn;

endmodule

// File: rtl/clk_shutdown_chk.sv
module clk_shutdown_chk #(
   parameter int NUM_OUT     = 6,
   parameter int SYNC_STAGES = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] div_clk,
   input logic               fb_div_clk,
   input logic               all_sd_n,
   input logic               out_en,
   input logic [NUM_OUT-1:0] q_clk,
   input logic [NUM_OUT-1:0] q_drv,
   input logic               fb_clk,
   input logic               fb_drv
);

   int unsigned oe_low_cnt;
   int unsigned all_low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_low_cnt  <= 0;
         all_low_cnt <= 0;
      end else begin
         if (out_en)                 oe_low_cnt <= 0;
         else if (oe_low_cnt < 64)   oe_low_cnt <= oe_low_cnt + 1;
         if (all_sd_n)               all_low_cnt <= 0;
         else if (all_low_cnt < 64)  all_low_cnt <= all_low_cnt + 1;
      end
   end

   // R1: outputs are quiet during reset
   always_comb begin
      if (!rst_n) begin
         a_r1_reset_quiet: assert (q_clk == '0 && q_drv == '0 && !fb_clk && !fb_drv);
      end
   end

   // R10: feedback repeats its divider one cycle later
   a_r10_fb_follows: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (fb_clk == $past(fb_div_clk)));

   // R8: master enable held low clears every drive flag
   a_r8_oe_forces_hiz: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_low_cnt >= SYNC_STAGES) |-> (q_drv == '0 && !fb_drv));

   // R9: all drive flags always move together
   a_r9_drive_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (q_drv == {NUM_OUT{fb_drv}}));

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
         // R2: a gated output is high only when its divider was high
         a_r2_high_needs_div: assert property (@(posedge clk) disable iff (!rst_n)
            q_clk[i] |-> $past(div_clk[i]));

         // R4: a running pulse cannot be cut while its divider stays high
         a_r4_no_runt: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(q_clk[i]) && $past(div_clk[i])) |-> q_clk[i]);

         // R6: an output cannot start in the middle of a high phase
         a_r6_full_first_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(q_clk[i]) && $past(div_clk[i]) && $past(div_clk[i], 2)) |-> !q_clk[i]);

         // R7: once the common stop has settled, no new pulse may start
         a_r7_common_blocks_rise: assert property (@(posedge clk) disable iff (!rst_n)
            ((all_low_cnt > SYNC_STAGES + 1) && !$past(q_clk[i])) |-> !q_clk[i]);
      end
   endgenerate

endmodule

bind clk_shutdown_ctrl clk_shutdown_chk #(
   .NUM_OUT     (NUM_OUT),
   .SYNC_STAGES (SYNC_STAGES)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .div_clk    (div_clk),
   .fb_div_clk (fb_div_clk),
   .all_sd_n   (all_sd_n),
   .out_en     (out_en),
   .q_clk      (q_clk),
   .q_drv      (q_drv),
   .fb_clk     (fb_clk),
   .fb_drv     (fb_drv)
);

// File: tb/test_clk_shutdown_ctrl.sv
`timescale 1ns/1ps
module test_clk_shutdown_ctrl;

   localparam int N      = 6;
   localparam int FB_HP  = 4;
   localparam int HP [N] = '{3, 3, 4, 4, 5, 6};

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] div_clk = '0;
   logic         fb_div_clk = 1'b0;
   logic [N-2:0] grp_sd_n = '1;
   logic         all_sd_n = 1'b1;
   logic         out_en = 1'b1;
   logic [N-1:0] q_clk;
   logic [N-1:0] q_drv;
   logic         fb_clk;
   logic         fb_drv;

   int div_cnt [N];
   int fb_cnt;
   int run_len [N];
   int runt_err [N];
   int pulses [N];
   logic [N-1:0] q_prev;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   clk_shutdown_ctrl i_clk_shutdown_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .div_clk    (div_clk),
      .fb_div_clk (fb_div_clk),
      .grp_sd_n   (grp_sd_n),
      .all_sd_n   (all_sd_n),
      .out_en     (out_en),
      .q_clk      (q_clk),
      .q_drv      (q_drv),
      .fb_clk     (fb_clk),
      .fb_drv     (fb_drv)
   );

   // Divider stimulus, updated on the falling edge
   always @(negedge clk) begin
      if (!rst_n) begin
         div_clk    <= '0;
         fb_div_clk <= 1'b0;
         fb_cnt     <= 0;
         for (int i = 0; i < N; i++) div_cnt[i] <= 0;
      end else begin
         for (int i = 0; i < N; i++) begin
            if (div_cnt[i] == HP[i] - 1) begin
               div_cnt[i] <= 0;
               div_clk[i] <= ~div_clk[i];
            end else begin
               div_cnt[i] <= div_cnt[i] + 1;
            end
         end
         if (fb_cnt == FB_HP - 1) begin
            fb_cnt     <= 0;
            fb_div_clk <= ~fb_div_clk;
         end else begin
            fb_cnt <= fb_cnt + 1;
         end
      end
   end

   // Pulse-width monitor on the gated outputs
   initial begin
      q_prev = '0;
      for (int i = 0; i < N; i++) begin
         run_len[i] = 0; runt_err[i] = 0; pulses[i] = 0;
      end
   end

   always @(posedge clk) begin
      #2;
      if (rst_n) begin
         for (int i = 0; i < N; i++) begin
            if (q_clk[i]) begin
               run_len[i] = run_len[i] + 1;
            end else if (q_prev[i]) begin
               pulses[i] = pulses[i] + 1;
               if (run_len[i] != HP[i]) runt_err[i] = runt_err[i] + 1;
               run_len[i] = 0;
            end
         end
         q_prev = q_clk;
      end
   end

   task automatic sample();
      @(posedge clk);
      #2;
   endtask

   task automatic wait_cycles(input int n);
      for (int k = 0; k < n; k++) sample();
   endtask

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Count samples where selected outputs differ from their divider or are not low
   task automatic watch(input int cycles, input logic [N-1:0] follow_mask,
                        output int bad_follow, output int bad_low, output int bad_fb);
      bad_follow = 0; bad_low = 0; bad_fb = 0;
      for (int k = 0; k < cycles; k++) begin
         sample();
         if (((q_clk ^ div_clk) & follow_mask) != '0) bad_follow++;
         if ((q_clk & ~follow_mask) != '0) bad_low++;
         if (fb_clk !== fb_div_clk) bad_fb++;
      end
   endtask

   function automatic int sum_runts();
      int s = 0;
      for (int i = 0; i < N; i++) s += runt_err[i];
      return s;
   endfunction

   task automatic t_reset();
      sample();
      chk(q_clk == '0, "R1", "gated outputs in reset", int'(q_clk), 0);
      chk(q_drv == '0 && !fb_drv, "R1", "drive flags in reset", int'({fb_drv, q_drv}), 0);
      chk(!fb_clk, "R1", "feedback in reset", int'(fb_clk), 0);
   endtask

   task automatic t_follow();
      int bf, bl, bfb;
      watch(40, '1, bf, bl, bfb);
      chk(bf == 0, "R2", "follow mismatches", bf, 0);
      chk(bfb == 0, "R10", "feedback mismatches", bfb, 0);
      chk(q_drv == '1 && fb_drv, "R8", "drive flags enabled", int'({fb_drv, q_drv}), 127);
   endtask

   task automatic t_group();
      int bf, bl, bfb;
      #1 grp_sd_n[0] = 1'b0;
      wait_cycles(20);
      watch(30, 6'b111100, bf, bl, bfb);
      chk(bl == 0, "R3", "outputs 0,1 not held low", bl, 0);
      chk(bf == 0, "R3", "outputs 2..5 disturbed", bf, 0);
      #1 grp_sd_n[0] = 1'b1;
      wait_cycles(20);
   endtask

   task automatic t_stop_mid_high();
      int bf, bl, bfb;
      int r0, p0;
      do sample(); while (!(div_clk[4] && div_cnt[4] == 0));
      r0 = runt_err[4]; p0 = pulses[4];
      #1 grp_sd_n[3] = 1'b0;
      wait_cycles(20);
      chk(runt_err[4] == r0, "R4", "runt on output 4 stop", runt_err[4] - r0, 0);
      chk(pulses[4] == p0 + 1, "R4", "in-flight pulse completed", pulses[4] - p0, 1);
      watch(20, 6'b101111, bf, bl, bfb);
      chk(bl == 0, "R4", "output 4 held low", bl, 0);
   endtask

   task automatic t_late_stop();
      int seen, bf, bl, bfb;
      do sample(); while (!(!div_clk[5] && div_cnt[5] == HP[5] - 2));
      #1 grp_sd_n[4] = 1'b0;
      seen = 0;
      for (int k = 0; k < 12; k++) begin
         sample();
         if (q_clk[5]) seen++;
      end
      chk(seen == HP[5], "R5", "pulse after late stop", seen, HP[5]);
      wait_cycles(4);
      watch(20, 6'b001111, bf, bl, bfb);
      chk(bl == 0, "R5", "outputs 4,5 low after stop", bl, 0);
   endtask

   task automatic t_restart();
      int bf, bl, bfb;
      int r0;
      r0 = sum_runts();
      #1 begin grp_sd_n[3] = 1'b1; grp_sd_n[4] = 1'b1; end
      wait_cycles(20);
      watch(30, '1, bf, bl, bfb);
      chk(bf == 0, "R6", "restarted outputs follow", bf, 0);
      chk(sum_runts() == r0, "R6", "runt on restart", sum_runts() - r0, 0);
   endtask

   task automatic t_common();
      int bf, bl, bfb;
      #1 all_sd_n = 1'b0;
      wait_cycles(20);
      watch(30, '0, bf, bl, bfb);
      chk(bl == 0, "R7", "main outputs not low", bl, 0);
      chk(bfb == 0, "R7", "feedback stopped", bfb, 0);
      #1 all_sd_n = 1'b1;
      wait_cycles(20);
   endtask

   task automatic t_master();
      int bf, bl, bfb;
      #1 out_en = 1'b0;
      wait_cycles(3);
      chk(q_drv == '0 && !fb_drv, "R8", "drive flags after enable low", int'({fb_drv, q_drv}), 0);
      watch(20, '1, bf, bl, bfb);
      chk(bf == 0, "R9", "gating altered by master enable", bf, 0);
      #1 grp_sd_n[0] = 1'b0;
      wait_cycles(20);
      chk(q_drv == '0 && !fb_drv, "R8", "drive flags with stop active", int'({fb_drv, q_drv}), 0);
      #1 out_en = 1'b1;
      wait_cycles(4);
      chk(q_drv == '1 && fb_drv, "R9", "drive flags with stop active", int'({fb_drv, q_drv}), 127);
      chk(q_clk[1:0] == 2'b00, "R3", "outputs 0,1 stopped", int'(q_clk[1:0]), 0);
      #1 grp_sd_n[0] = 1'b1;
      wait_cycles(20);
   endtask

   task automatic t_final();
      int tot;
      tot = 0;
      for (int i = 0; i < N; i++) tot += pulses[i];
      chk(sum_runts() == 0, "R4", "runt pulses overall", sum_runts(), 0);
      chk(tot > 50, "R4", "pulses observed", tot, 51);
   endtask

   initial begin
      wait_cycles(2);
      t_reset();
      #1 rst_n = 1'b1;
      wait_cycles(12);
      t_follow();
      t_group();
      t_stop_mid_high();
      t_late_stop();
      t_restart();
      t_common();
      t_master();
      t_final();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule